// File: doc/BRIEF.md
# Synchronous Rectifier Drive Sequencer

This block sequences the two gate-drive commands of the secondary-side synchronous rectifiers in an isolated half-bridge converter. It takes the two drive inputs relayed from the primary side and a set of digitised comparator flags: supply at 90 %, reference at 90 %, reference below 20 %, overvoltage tripped and overvoltage cleared. From these it decides, on every clock edge, what the rectifier gates may do. While the supply is still coming up the main drive is off. A small hold-low path keeps each gate down whenever the opposite input is high. Once the supply is valid the reference is allowed to rise and the outputs enter a soft-start. During soft-start the allowed on-time grows pulse by pulse, until the outputs follow the inputs with a fixed rising-edge delay.

Overvoltage is handled in two ways. If it arrives before the reference is up, the outputs are simply held off. If it arrives later, it is latched: both gates are driven on and the reference is discharged. The block releases only when the reference has fallen low and the overvoltage has cleared, and then it repeats the soft-start. When the drive inputs stop toggling for a programmable time, the block pulls both gates low for a fixed number of switching periods. It then stays quiet until input activity resumes.

The states are HOLD (supply not valid), SOFT (soft-start), RUN (normal drive), START_OV (startup overvoltage hold-off), FAULT (latched run-time overvoltage), DISCH (timed gate discharge) and OFF (parked after discharge). The transitions are: supply valid (HOLD to SOFT), soft-start complete (SOFT to RUN), early overvoltage (to START_OV), reference up (START_OV to RUN), late overvoltage (to FAULT), fault release (FAULT to SOFT), input timeout (SOFT or RUN to DISCH), discharge done (DISCH to OFF), activity resumes (OFF to HOLD) and supply lost (any state to HOLD). Every output is registered and reflects the inputs sampled at the same clock edge.

Top module: `srdrv_supervisor`

## Requirements
- R1: After reset, and whenever vcc_ok was low at the previous clock edge, out_a, out_b and vref_release are low.
- R2: While vcc_ok is low, hold_a equals in_b and hold_b equals in_a, each as sampled at the previous clock edge.
- R3: vref_release rises only at an edge where vcc_ok is high. With no overvoltage, that same edge starts soft-start, and ss_active goes high.
- R4: During soft-start the k-th completed input pulse (k = 1..SS_STEPS) drives its output high only in high cycles j (j = 0 is the first cycle the input is high) with EDGE_DLY <= j < EDGE_DLY + k*SS_WSTEP. The block moves to normal drive, and ss_active drops, at the edge where the SS_STEPS-th pulse falls.
- R5: In normal drive an output goes high at high cycle j = EDGE_DLY of its input and low one cycle after the input falls. A pulse of EDGE_DLY cycles or fewer gives no output.
- R6: An ovp_over seen while vref_ok is low holds both outputs low. The outputs stay low until an edge with vref_ok high and ovp_over low, after which they follow the R5 rule.
- R7: An ovp_over seen while vref_ok is high (in soft-start or normal drive) drives out_a and out_b high and vref_discharge high, with vref_release low. The state persists after ovp_over drops.
- R8: The fault of R7 is left only at an edge where both vref_low and ovp_clear are high. Either flag alone has no effect. Release re-enters soft-start.
- R9: After IDLE_LIMIT cycles with no edge on in_a or in_b during soft-start or normal drive, both outputs go low. hold_a and hold_b are then high for exactly DIS_PULSES*PULSE_PERIOD cycles, then low.
- R10: After the discharge, an edge on either input with vcc_ok high returns the block to the HOLD state, and soft-start follows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Supply has reached 90 % |
| vref_ok | input | 1 | Reference has reached 90 % |
| vref_low | input | 1 | Reference is below 20 % |
| ovp_over | input | 1 | Overvoltage comparator tripped |
| ovp_clear | input | 1 | Overvoltage sense back below the clear level |
| in_a | input | 1 | Drive command for rectifier A |
| in_b | input | 1 | Drive command for rectifier B |
| out_a | output | 1 | Main gate drive A |
| out_b | output | 1 | Main gate drive B |
| hold_a | output | 1 | Hold-low / discharge pull on gate A |
| hold_b | output | 1 | Hold-low / discharge pull on gate B |
| vref_release | output | 1 | Allow the reference to rise |
| vref_discharge | output | 1 | Discharge the reference |
| ss_active | output | 1 | Soft-start in progress |

## Verification
A wrong state appears at the ports on the very next edge, because every output is decoded from the next state. A missed fault latch shows as outputs that follow the inputs instead of both staying high. A missed release shows as vref_discharge staying high. A miscounted soft-start step shows as a pulse that is one width step too short or too long. Timer errors in the idle or discharge counters shift the hold pulse by whole cycles or change its length, so the bench checks every cycle of that window.

// File: rtl/srdrv_pkg.sv
package srdrv_pkg;

    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,
        ST_SOFT     = 3'd1,
        ST_RUN      = 3'd2,
        ST_START_OV = 3'd3,
        ST_FAULT    = 3'd4,
        ST_DISCH    = 3'd5,
        ST_OFF      = 3'd6
    } srdrv_state_e;

    function automatic int unsigned srdrv_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/srdrv_pulse_timer.sv
module srdrv_pulse_timer #(
    parameter int unsigned CNT_MAX = 34,
    parameter int unsigned CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    output logic             rise,
    output logic             fall,
    output logic [CNT_W-1:0] cnt
);

    logic pin_q;

    assign rise = pin & ~pin_q;
    assign fall = ~pin & pin_q;

    // cnt = number of earlier edges at which pin was high in the current pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            cnt   <= '0;
        end else begin
            pin_q <= pin;
            if (!pin) begin
                cnt <= '0;
            end else if (cnt != CNT_W'(CNT_MAX)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/srdrv_activity.sv
module srdrv_activity #(
    parameter int unsigned IDLE_LIMIT = 256,
    parameter int unsigned DIS_CYC    = 128,
    parameter int unsigned IDLE_W     = 8,
    parameter int unsigned DIS_W      = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_edge,
    input  logic idle_en,
    input  logic dis_en,
    output logic idle_expire,
    output logic dis_done
);

    logic [IDLE_W-1:0] idle_cnt;
    logic [DIS_W-1:0]  dis_cnt;

    assign idle_expire = idle_en && !any_edge && (idle_cnt == IDLE_W'(IDLE_LIMIT - 1));
    assign dis_done    = dis_en && (dis_cnt == DIS_W'(DIS_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!idle_en || any_edge) begin
            idle_cnt <= '0;
        end else if (!idle_expire) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_cnt <= '0;
        end else if (!dis_en) begin
            dis_cnt <= '0;
        end else if (!dis_done) begin
            dis_cnt <= dis_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/srdrv_fsm.sv
module srdrv_fsm
    import srdrv_pkg::*;
#(
    parameter int unsigned EDGE_DLY = 2,
    parameter int unsigned SS_STEPS = 4,
    parameter int unsigned SS_WSTEP = 8,
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned SS_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vcc_ok,
    input  logic             vref_ok,
    input  logic             vref_low,
    input  logic             ovp_over,
    input  logic             ovp_clear,
    input  logic             in_a,
    input  logic             in_b,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             any_fall,
    input  logic             any_edge,
    input  logic             idle_expire,
    input  logic             dis_done,
    output logic             idle_en,
    output logic             dis_en,
    output logic             out_a,
    output logic             out_b,
    output logic             hold_a,
    output logic             hold_b,
    output logic             vref_release,
    output logic             vref_discharge,
    output logic             ss_active
);

    srdrv_state_e    state, state_nxt, ov_target;
    logic [SS_W-1:0] ss_cnt;
    logic [SS_W-1:0] ss_eff;
    int unsigned     ss_lim;
    logic            run_a, run_b;
    logic            soft_a, soft_b;
    logic            ss_last;

    assign idle_en   = (state == ST_SOFT) || (state == ST_RUN);
    assign dis_en    = (state == ST_DISCH);
    assign ov_target = vref_ok ? ST_FAULT : ST_START_OV;
    assign ss_eff    = (state == ST_SOFT) ? ss_cnt : '0;
    assign ss_last   = (ss_cnt == SS_W'(SS_STEPS - 1));
    assign ss_lim    = EDGE_DLY + (32'(ss_eff) + 1) * SS_WSTEP;

    assign run_a  = in_a && (32'(cnt_a) >= EDGE_DLY);
    assign run_b  = in_b && (32'(cnt_b) >= EDGE_DLY);
    assign soft_a = run_a && (32'(cnt_a) < ss_lim);
    assign soft_b = run_b && (32'(cnt_b) < ss_lim);

    always_comb begin
        state_nxt = state;
        if (!vcc_ok) begin
            state_nxt = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    state_nxt = ovp_over ? ov_target : ST_SOFT;
                end
                ST_SOFT: begin
                    if (ovp_over) begin
                        state_nxt = ov_target;
                    end else if (idle_expire) begin
                        state_nxt = ST_DISCH;
                    end else if (any_fall && ss_last) begin
                        state_nxt = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (ovp_over) begin
                        state_nxt = ov_target;
                    end else if (idle_expire) begin
                        state_nxt = ST_DISCH;
                    end
                end
                ST_START_OV: begin
                    if (vref_ok) begin
                        state_nxt = ovp_over ? ST_FAULT : ST_RUN;
                    end
                end
                ST_FAULT: begin
                    if (vref_low && ovp_clear) begin
                        state_nxt = ST_SOFT;
                    end
                end
                ST_DISCH: begin
                    if (dis_done) begin
                        state_nxt = ST_OFF;
                    end
                end
                ST_OFF: begin
                    if (any_edge) begin
                        state_nxt = ST_HOLD;
                    end
                end
                default: state_nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HOLD;
            ss_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state != ST_SOFT) begin
                ss_cnt <= '0;
            end else if (any_fall && !ss_last) begin
                ss_cnt <= ss_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_a          <= 1'b0;
            out_b          <= 1'b0;
            hold_a         <= 1'b0;
            hold_b         <= 1'b0;
            vref_release   <= 1'b0;
            vref_discharge <= 1'b0;
            ss_active      <= 1'b0;
        end else begin
            out_a          <= 1'b0;
            out_b          <= 1'b0;
            hold_a         <= 1'b0;
            hold_b         <= 1'b0;
            vref_release   <= 1'b1;
            vref_discharge <= 1'b0;
            ss_active      <= 1'b0;
            unique case (state_nxt)
                ST_HOLD: begin
                    hold_a       <= in_b;
                    hold_b       <= in_a;
                    vref_release <= 1'b0;
                end
                ST_SOFT: begin
                    out_a     <= soft_a;
                    out_b     <= soft_b;
                    ss_active <= 1'b1;
                end
                ST_RUN: begin
                    out_a <= run_a;
                    out_b <= run_b;
                end
                ST_START_OV: begin
                end
                ST_FAULT: begin
                    out_a          <= 1'b1;
                    out_b          <= 1'b1;
                    vref_release   <= 1'b0;
                    vref_discharge <= 1'b1;
                end
                ST_DISCH: begin
                    hold_a <= 1'b1;
                    hold_b <= 1'b1;
                end
                ST_OFF: begin
                end
                default: begin
                    vref_release <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/srdrv_supervisor.sv
module srdrv_supervisor
    import srdrv_pkg::*;
#(
    parameter int unsigned EDGE_DLY     = 2,
    parameter int unsigned SS_STEPS     = 4,
    parameter int unsigned SS_WSTEP     = 8,
    parameter int unsigned IDLE_LIMIT   = 256,
    parameter int unsigned DIS_PULSES   = 4,
    parameter int unsigned PULSE_PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic vref_ok,
    input  logic vref_low,
    input  logic ovp_over,
    input  logic ovp_clear,
    input  logic in_a,
    input  logic in_b,
    output logic out_a,
    output logic out_b,
    output logic hold_a,
    output logic hold_b,
    output logic vref_release,
    output logic vref_discharge,
    output logic ss_active
);

    localparam int unsigned CNT_MAX = EDGE_DLY + SS_STEPS * SS_WSTEP;
    localparam int unsigned CNT_W   = srdrv_width(CNT_MAX);
    localparam int unsigned SS_W    = srdrv_width(SS_STEPS);
    localparam int unsigned DIS_CYC = DIS_PULSES * PULSE_PERIOD;
    localparam int unsigned IDLE_W  = srdrv_width(IDLE_LIMIT);
    localparam int unsigned DIS_W   = srdrv_width(DIS_CYC);
    localparam int unsigned N_CH    = 2;

    logic [N_CH-1:0]  pins;
    logic [N_CH-1:0]  rise;
    logic [N_CH-1:0]  fall;
    logic [CNT_W-1:0] cnt [N_CH];
    logic             any_edge, any_fall;
    logic             idle_en, dis_en, idle_expire, dis_done;

    assign pins     = {in_b, in_a};
    assign any_edge = (|rise) | (|fall);
    assign any_fall = |fall;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        srdrv_pulse_timer #(
            .CNT_MAX (CNT_MAX),
            .CNT_W   (CNT_W)
        ) i_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[c]),
            .rise  (rise[c]),
            .fall  (fall[c]),
            .cnt   (cnt[c])
        );
    end

    srdrv_activity #(
        .IDLE_LIMIT (IDLE_LIMIT),
        .DIS_CYC    (DIS_CYC),
        .IDLE_W     (IDLE_W),
        .DIS_W      (DIS_W)
    ) i_activity (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_edge    (any_edge),
        .idle_en     (idle_en),
        .dis_en      (dis_en),
        .idle_expire (idle_expire),
        .dis_done    (dis_done)
    );

    srdrv_fsm #(
        .EDGE_DLY (EDGE_DLY),
        .SS_STEPS (SS_STEPS),
        .SS_WSTEP (SS_WSTEP),
        .CNT_W    (CNT_W),
        .SS_W     (SS_W)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .vcc_ok         (vcc_ok),
        .vref_ok        (vref_ok),
        .vref_low       (vref_low),
        .ovp_over       (ovp_over),
        .ovp_clear      (ovp_clear),
        .in_a           (in_a),
        .in_b           (in_b),
        .cnt_a          (cnt[0]),
        .cnt_b          (cnt[1]),
        .any_fall       (any_fall),
        .any_edge       (any_edge),
        .idle_expire    (idle_expire),
        .dis_done       (dis_done),
        .idle_en        (idle_en),
        .dis_en         (dis_en),
        .out_a          (out_a),
        .out_b          (out_b),
        .hold_a         (hold_a),
        .hold_b         (hold_b),
        .vref_release   (vref_release),
        .vref_discharge (vref_discharge),
        .ss_active      (ss_active)
    );

endmodule

// File: rtl/srdrv_supervisor_chk.sv
module srdrv_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic vcc_ok,
    input logic vref_ok,
    input logic vref_low,
    input logic ovp_over,
    input logic ovp_clear,
    input logic in_a,
    input logic in_b,
    input logic out_a,
    input logic out_b,
    input logic hold_a,
    input logic hold_b,
    input logic vref_release,
    input logic vref_discharge,
    input logic ss_active
);

    a_r1_vcc_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (!out_a && !out_b && !vref_release));

    a_r2_cross_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (hold_a == $past(in_b)) && (hold_b == $past(in_a)));

    a_r3_release_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vref_release) |-> $past(vcc_ok));

    a_r5_out_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_a && !vref_discharge) |-> $past(in_a));

    a_r5_outb_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_b && !vref_discharge) |-> $past(in_b));

    a_r6_early_ovp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && ovp_over && !vref_ok && !vref_discharge) |=> (!out_a && !out_b));

    a_r7_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vref_discharge) |-> ($past(ovp_over) && $past(vref_ok)));

    a_r7_soft_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> !vref_discharge);

    a_r8_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && vref_discharge && !(vref_low && ovp_clear)) |=> vref_discharge);

    a_r9_pull_excludes_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_a && hold_b) |-> (!out_a && !out_b));

endmodule

bind srdrv_supervisor srdrv_supervisor_chk i_chk (.*);

// File: tb/test_srdrv_supervisor.sv
module test_srdrv_supervisor;

    localparam int D    = 2;
    localparam int S    = 4;
    localparam int W    = 2;
    localparam int IDLE = 40;
    localparam int DP   = 3;
    localparam int PER  = 8;
    localparam int DIS  = DP * PER;
    localparam logic [6:0] ALL = 7'b1111111;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, vcc_ok, vref_ok, vref_low, ovp_over, ovp_clear, in_a, in_b;
    logic out_a, out_b, hold_a, hold_b, vref_release, vref_discharge, ss_active;
    logic [6:0] act;

    assign act = {out_a, out_b, hold_a, hold_b, vref_release, vref_discharge, ss_active};

    srdrv_supervisor #(
        .EDGE_DLY (D), .SS_STEPS (S), .SS_WSTEP (W),
        .IDLE_LIMIT (IDLE), .DIS_PULSES (DP), .PULSE_PERIOD (PER)
    ) i_srdrv_supervisor (
        .clk (clk), .rst_n (rst_n), .vcc_ok (vcc_ok), .vref_ok (vref_ok),
        .vref_low (vref_low), .ovp_over (ovp_over), .ovp_clear (ovp_clear),
        .in_a (in_a), .in_b (in_b), .out_a (out_a), .out_b (out_b),
        .hold_a (hold_a), .hold_b (hold_b), .vref_release (vref_release),
        .vref_discharge (vref_discharge), .ss_active (ss_active)
    );

    typedef struct {
        logic [6:0] exp;
        logic [6:0] msk;
        string      tag;
    } item_t;

    item_t sbq[$];
    item_t cur;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    // monitor: one expected item per driven cycle, compared after the edge
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            cur = sbq.pop_front();
            if (cur.msk != 7'b0) begin
                n_chk++;
                if ((act & cur.msk) != (cur.exp & cur.msk)) begin
                    n_bad++;
                    $display("FAIL %s: actual=%b expected=%b", cur.tag, act, cur.exp);
                end
            end
        end
    end

    // called at a falling edge; applies inputs for the next rising edge
    task automatic cyc(input logic ia, input logic ib, input logic [6:0] e,
                       input logic [6:0] m, input string t);
        in_a = ia;
        in_b = ib;
        sbq.push_back('{exp: e, msk: m, tag: t});
        @(negedge clk);
    endtask

    // k = 0: normal drive rule, k > 0: k-th soft-start pulse; pd: expect discharge in gap
    task automatic pulse(input bit ch, input int len, input int gap, input int k,
                         input bit pd, input string t);
        for (int j = 0; j < len; j++) begin
            logic hi;
            hi = (j >= D) && ((k == 0) || (j < D + k * W));
            cyc(ch == 1'b0, ch == 1'b1,
                {(ch == 1'b0) && hi, (ch == 1'b1) && hi, 2'b00, 1'b1, 1'b0, k != 0},
                ALL, t);
        end
        for (int m = 0; m < gap; m++) begin
            logic hd;
            hd = pd && (m >= IDLE) && (m < IDLE + DIS);
            cyc(1'b0, 1'b0, {2'b00, hd, hd, 1'b1, 1'b0, (k != 0) && (k < S)}, ALL, t);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; vcc_ok = 1'b0; vref_ok = 1'b0; vref_low = 1'b0;
        ovp_over = 1'b0; ovp_clear = 1'b0; in_a = 1'b0; in_b = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (act != 7'b0) begin
            n_bad++;
            $display("FAIL R1 reset state: actual=%b expected=%b", act, 7'b0);
        end
        rst_n = 1'b1;

        // R1 / R2: supply not valid, cross-coupled hold-low
        cyc(1'b1, 1'b0, 7'b0001000, ALL, "R2 hold_b follows in_a");
        cyc(1'b0, 1'b1, 7'b0010000, ALL, "R2 hold_a follows in_b");
        cyc(1'b1, 1'b1, 7'b0011000, ALL, "R2 both holds");
        cyc(1'b0, 1'b0, 7'b0000000, ALL, "R1 held off");

        // R3: supply valid -> reference released, soft-start
        vcc_ok = 1'b1;
        cyc(1'b0, 1'b0, 7'b0000101, ALL, "R3 release and soft-start");

        // R4: widening soft-start pulses
        for (int k = 1; k <= S; k++) pulse(1'b0, 10, 4, k, 1'b0, "R4 soft-start pulse");

        // R5: normal drive with edge delay
        pulse(1'b0, 10, 4, 0, 1'b0, "R5 run pulse A");
        pulse(1'b1, 6, 4, 0, 1'b0, "R5 run pulse B");
        pulse(1'b0, 2, 4, 0, 1'b0, "R5 short pulse suppressed");

        // R6: overvoltage before reference is up
        ovp_over = 1'b1;
        for (int j = 0; j < 6; j++) cyc(1'b1, 1'b0, 7'b0000100, ALL, "R6 early ovp holds off");
        ovp_over = 1'b0;
        for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, 7'b0000100, ALL, "R6 hold-off gap");
        for (int j = 0; j < 6; j++) cyc(1'b0, 1'b1, 7'b0000100, ALL, "R6 still off without vref_ok");
        vref_ok = 1'b1;
        cyc(1'b0, 1'b0, 7'b0000100, ALL, "R6 vref up");
        pulse(1'b0, 8, 4, 0, 1'b0, "R6 follows inputs after vref up");

        // R7 / R8: run-time overvoltage latch and release
        ovp_over = 1'b1;
        cyc(1'b0, 1'b0, 7'b1100010, ALL, "R7 fault entry");
        ovp_over = 1'b0;
        for (int j = 0; j < 4; j++) cyc(1'b1, 1'b0, 7'b1100010, ALL, "R7 fault latched");
        for (int j = 0; j < 2; j++) cyc(1'b0, 1'b0, 7'b1100010, ALL, "R7 fault latched");
        vref_low = 1'b1;
        for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, 7'b1100010, ALL, "R8 vref_low alone");
        vref_low = 1'b0;
        ovp_clear = 1'b1;
        for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, 7'b1100010, ALL, "R8 ovp_clear alone");
        vref_low = 1'b1;
        cyc(1'b0, 1'b0, 7'b0000101, ALL, "R8 release to soft-start");
        vref_low = 1'b0;
        ovp_clear = 1'b0;
        for (int k = 1; k <= S; k++) pulse(1'b1, 9, 4, k, 1'b0, "R8 soft-start after fault");

        // R9: input timeout and timed discharge
        pulse(1'b1, 6, IDLE + DIS + 6, 0, 1'b1, "R9 idle discharge window");

        // R10: activity resumes
        cyc(1'b1, 1'b0, 7'b0001000, ALL, "R10 edge returns to hold");
        cyc(1'b1, 1'b0, 7'b0000101, ALL, "R10 soft-start after hold");
        cyc(1'b1, 1'b0, 7'b1000101, ALL, "R10 first soft pulse");
        cyc(1'b1, 1'b0, 7'b1000101, ALL, "R10 first soft pulse");
        cyc(1'b1, 1'b0, 7'b0000101, ALL, "R10 soft width end");
        cyc(1'b1, 1'b0, 7'b0000101, ALL, "R10 soft width end");
        cyc(1'b0, 1'b0, 7'b0000101, ALL, "R10 pulse fall");

        // R1: supply lost from soft-start
        vcc_ok = 1'b0;
        cyc(1'b0, 1'b1, 7'b0010000, ALL, "R1 vcc loss");
        cyc(1'b0, 1'b0, 7'b0000000, ALL, "R1 vcc loss");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule